// File: doc/BRIEF.md
# Master video sync generator

This block produces the horizontal and vertical/field sync outputs for an interlaced video encoder when the encoder is the timing master. A horizontal counter runs on the pixel clock and wraps at the end of each line. A vertical counter steps once per wrapped line and wraps at the end of each frame. The line length and the frame length are parameters.

The sync outputs are decoded from the counter position using small control fields that a register bank outside the block supplies. The HSYNC pulse width, the offset between HSYNC and the vertical output, and the vertical pulse width are each chosen by a 2-bit code from a fixed, non-linear set of pixel-clock counts. A skew field moves every sync edge by 0 to 3 clocks relative to the pixel data, and an odd skew swaps the Cr/Cb phase.

The meaning of one shared 2-bit field depends on the timing mode. In the pulse mode it sets the VSYNC width. In the field mode its low bit adds a 32 µs delay to one edge of the field signal. The internal counters are restarted by a full low-high-low pulse on a control bit. That restart is needed after power-up and after any timing mode change.

Top module: `vsg_master`

## Requirements
- R1: While rst_ni is low, hsync_no and vsync_no are both high, and both counters are at line 0, clock 0.
- R2: The position is (line, clock), with clock running from 0 to CLKS_PER_LINE-1 and line from 0 to LINES_PER_FRAME-1. Both outputs are registered: the value seen after a clock edge belongs to the position held before that edge. In master mode hsync_no is low on every line for clock values in [skew, skew+W). W is 1, 4, 16 or 128 for hs_width_i codes 0, 1, 2 and 3.
- R3: skew_i (0 to 3) delays hsync_no, the vsync_no pulse and both field edges by that number of clocks.
- R4: In timing mode 2 (mode_i = 2'd2), vsync_no is low only on line 0, for clock values in [B, B+V). B = skew + D, and V is 1, 4, 16 or 128 for shared_i codes 0 to 3.
- R5: The offset D is 0, 4, 8 or 16 clocks for hs_vs_off_i codes 0, 1, 2 and 3.
- R6: In timing mode 1 (mode_i = 2'd1), vsync_no is a field level. It goes low at line 0, clock B+E, and goes high at line H, clock B, where H = (LINES_PER_FRAME+1)/2. E is 0 when shared_i[0] = 0. When shared_i[0] = 1, E is 32 µs expressed in clocks, (CLK_HZ/1000)*32/1000, which is 864 at 27 MHz. shared_i[1] has no effect in this mode.
- R7: In timing modes 0 and 3, vsync_no is low for the whole of line 0 and high on every other line.
- R8: When master_i is 0, hsync_no and vsync_no are both high from the next clock edge on.
- R9: When cnt_rst_i is sampled low after having been sampled high, and a low-to-high change was seen since reset, the counters return to line 0, clock 0 at that edge. A high level already present when reset is released, followed by a fall, does not clear the counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 selects master timing; 0 holds both outputs high |
| mode_i | input | 2 | Timing mode 0 to 3 |
| hs_width_i | input | 2 | HSYNC width code |
| hs_vs_off_i | input | 2 | HSYNC to vertical output offset code |
| shared_i | input | 2 | VSYNC width code in mode 2; bit 0 is the long field delay select in mode 1 |
| skew_i | input | 2 | Sync skew against pixel data, 0 to 3 clocks |
| cnt_rst_i | input | 1 | Counter restart control bit, acts on a low-high-low pulse |
| hsync_no | output | 1 | Horizontal sync, active low, registered |
| vsync_no | output | 1 | Vertical sync or field level, active low, registered |

## Verification
The bench builds the block with 200 clocks per line, 10 lines per frame and a 2 MHz clock setting. With these values the long field delay is 64 clocks, the field boundary falls on line 5, and a full frame is only 2000 cycles. This lets every code of every field, the widest 128-clock pulses and both field edges be compared cycle by cycle against a model over complete frames. The small frame also brings the orphan-fall case within reach: reset is released with the control bit high, and the bench shows that the following fall leaves the frame phase untouched.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef enum logic [1:0] {
    TM_LINE0 = 2'd0,
    TM_FIELD = 2'd1,
    TM_VPULSE = 2'd2,
    TM_LINE3 = 2'd3
  } tmode_e;

  function automatic logic [7:0] width_of(input logic [1:0] code);
    case (code)
      2'd0: width_of = 8'd1;
      2'd1: width_of = 8'd4;
      2'd2: width_of = 8'd16;
      default: width_of = 8'd128;
    endcase
  endfunction

  function automatic logic [4:0] offset_of(input logic [1:0] code);
    case (code)
      2'd0: offset_of = 5'd0;
      2'd1: offset_of = 5'd4;
      2'd2: offset_of = 5'd8;
      default: offset_of = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/vsg_clr_detect.sv
module vsg_clr_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic clr_o
);
  logic q, armed;

  // q resets high so a level already high at release is not seen as a rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q     <= 1'b1;
      armed <= 1'b0;
    end else begin
      q <= pulse_i;
      if (pulse_i && !q) armed <= 1'b1;
      else if (!pulse_i && q) armed <= 1'b0;
    end
  end

  assign clr_o = armed && q && !pulse_i;
endmodule

// File: rtl/vsg_timebase.sv
module vsg_timebase #(
  parameter int CPL = 1728,
  parameter int LPF = 625,
  localparam int HW = $clog2(CPL),
  localparam int VW = $clog2(LPF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o
);
  localparam logic [HW-1:0] H_LAST = HW'(CPL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(LPF - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_o <= '0;
      v_o <= '0;
    end else if (clr_i) begin
      h_o <= '0;
      v_o <= '0;
    end else if (h_o == H_LAST) begin
      h_o <= '0;
      v_o <= (v_o == V_LAST) ? '0 : v_o + 1'b1;
    end else begin
      h_o <= h_o + 1'b1;
    end
  end
endmodule

// File: rtl/vsg_hs_gen.sv
module vsg_hs_gen import vsg_pkg::*; #(
  parameter int HW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] h_i,
  input  logic          master_i,
  input  logic [1:0]    width_i,
  input  logic [1:0]    skew_i,
  output logic          hsync_no
);
  logic [HW:0] hx, start, stop;
  logic        act;

  assign hx    = {1'b0, h_i};
  assign start = (HW+1)'(skew_i);
  assign stop  = start + (HW+1)'(width_of(width_i));
  assign act   = (hx >= start) && (hx < stop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hsync_no <= 1'b1;
    else         hsync_no <= !(master_i && act);
  end
endmodule

// File: rtl/vsg_fv_gen.sv
module vsg_fv_gen import vsg_pkg::*; #(
  parameter int HW   = 11,
  parameter int VW   = 10,
  parameter int LPF  = 625,
  parameter int LONG = 864
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  input  logic          master_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    off_i,
  input  logic [1:0]    shared_i,
  input  logic [1:0]    skew_i,
  output logic          vsync_no
);
  localparam logic [VW-1:0] HALF   = VW'((LPF + 1) / 2);
  localparam logic [HW:0]   LONG_C = (HW+1)'(LONG);

  logic [HW:0] hx, base, pulse_end, first_start;
  logic        line0, after_start, before_end, act;

  assign hx          = {1'b0, h_i};
  assign base        = (HW+1)'(skew_i) + (HW+1)'(offset_of(off_i));
  assign pulse_end   = base + (HW+1)'(width_of(shared_i));
  assign first_start = base + (shared_i[0] ? LONG_C : '0);

  always_comb begin
    line0       = (v_i == '0);
    after_start = !line0 || (hx >= first_start);
    before_end  = (v_i < HALF) || ((v_i == HALF) && (hx < base));
    case (tmode_e'(mode_i))
      TM_FIELD:  act = after_start && before_end;
      TM_VPULSE: act = line0 && (hx >= base) && (hx < pulse_end);
      default:   act = line0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vsync_no <= 1'b1;
    else         vsync_no <= !(master_i && act);
  end
endmodule

// File: rtl/vsg_master.sv
module vsg_master #(
  parameter int CLKS_PER_LINE   = 1728,
  parameter int LINES_PER_FRAME = 625,
  parameter int CLK_HZ          = 27_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       master_i,
  input  logic [1:0] mode_i,
  input  logic [1:0] hs_width_i,
  input  logic [1:0] hs_vs_off_i,
  input  logic [1:0] shared_i,
  input  logic [1:0] skew_i,
  input  logic       cnt_rst_i,
  output logic       hsync_no,
  output logic       vsync_no
);
  localparam int HW   = $clog2(CLKS_PER_LINE);
  localparam int VW   = $clog2(LINES_PER_FRAME);
  localparam int LONG = (CLK_HZ / 1000) * 32 / 1000;

  logic          clr;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;

  vsg_clr_detect u_clr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (cnt_rst_i),
    .clr_o   (clr)
  );

  vsg_timebase #(.CPL(CLKS_PER_LINE), .LPF(LINES_PER_FRAME)) u_tb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .h_o    (h_cnt),
    .v_o    (v_cnt)
  );

  vsg_hs_gen #(.HW(HW)) u_hs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .h_i      (h_cnt),
    .master_i (master_i),
    .width_i  (hs_width_i),
    .skew_i   (skew_i),
    .hsync_no (hsync_no)
  );

  vsg_fv_gen #(.HW(HW), .VW(VW), .LPF(LINES_PER_FRAME), .LONG(LONG)) u_fv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .h_i      (h_cnt),
    .v_i      (v_cnt),
    .master_i (master_i),
    .mode_i   (mode_i),
    .off_i    (hs_vs_off_i),
    .shared_i (shared_i),
    .skew_i   (skew_i),
    .vsync_no (vsync_no)
  );
endmodule

// File: rtl/vsg_master_chk.sv
module vsg_master_chk #(
  parameter int HW = 11,
  parameter int VW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          master_i,
  input logic [1:0]    mode_i,
  input logic          hsync_no,
  input logic          vsync_no,
  input logic          clr_i,
  input logic [HW-1:0] h_i,
  input logic [VW-1:0] v_i
);
  logic [8:0] hs_run, vs_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_run <= '0;
      vs_run <= '0;
    end else begin
      hs_run <= hsync_no ? '0 : ((hs_run == 9'h1ff) ? hs_run : hs_run + 1'b1);
      vs_run <= (vsync_no || mode_i != 2'd2) ? '0
              : ((vs_run == 9'h1ff) ? vs_run : vs_run + 1'b1);
    end
  end

  // widest window 128 plus a skew step of up to 3 while a pulse is open
  p_hs_bounded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_run <= 9'd131);

  p_vs_bounded_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_run <= 9'd132);

  p_slave_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |=> (hsync_no && vsync_no));

  p_clr_origin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (h_i == '0 && v_i == '0));

  p_line_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_i != $past(v_i)) |-> (h_i == '0));
endmodule

bind vsg_master vsg_master_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .master_i (master_i),
  .mode_i   (mode_i),
  .hsync_no (hsync_no),
  .vsync_no (vsync_no),
  .clr_i    (clr),
  .h_i      (h_cnt),
  .v_i      (v_cnt)
);

// File: tb/vsg_master_test.sv
module vsg_master_test;
  localparam int CPL   = 200;
  localparam int LPF   = 10;
  localparam int HZ    = 2_000_000;
  localparam int LONG  = (HZ / 1000) * 32 / 1000;
  localparam int HALF  = (LPF + 1) / 2;
  localparam int FRAME = CPL * LPF;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic master_i = 1'b1;
  logic [1:0] mode_i = 2'd2;
  logic [1:0] hs_width_i = '0, hs_vs_off_i = '0, shared_i = '0, skew_i = '0;
  logic cnt_rst_i = 1'b0;
  logic hsync_no, vsync_no;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  vsg_master #(.CLKS_PER_LINE(CPL), .LINES_PER_FRAME(LPF), .CLK_HZ(HZ)) uut (
    .clk_i, .rst_ni, .master_i, .mode_i, .hs_width_i, .hs_vs_off_i,
    .shared_i, .skew_i, .cnt_rst_i, .hsync_no, .vsync_no
  );

  function automatic int wid(input logic [1:0] c);
    case (c) 2'd0: return 1; 2'd1: return 4; 2'd2: return 16; default: return 128; endcase
  endfunction

  function automatic int offs(input logic [1:0] c);
    case (c) 2'd0: return 0; 2'd1: return 4; 2'd2: return 8; default: return 16; endcase
  endfunction

  function automatic logic exp_hs(input int h);
    int s = int'(skew_i);
    if (!master_i) return 1'b1;
    return !(h >= s && h < s + wid(hs_width_i));
  endfunction

  function automatic logic exp_vs(input int h, input int v);
    int b = int'(skew_i) + offs(hs_vs_off_i);
    int st = b + (shared_i[0] ? LONG : 0);
    if (!master_i) return 1'b1;
    case (mode_i)
      2'd1: return !((v > 0 || h >= st) && (v < HALF || (v == HALF && h < b)));
      2'd2: return !(v == 0 && h >= b && h < b + wid(shared_i));
      default: return !(v == 0);
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic m, input logic [1:0] md, input logic [1:0] w,
                     input logic [1:0] o, input logic [1:0] sh, input logic [1:0] sk);
    @(negedge clk_i);
    master_i = m; mode_i = md; hs_width_i = w; hs_vs_off_i = o;
    shared_i = sh; skew_i = sk;
  endtask

  // low-high-low on the control bit; returns at the negedge after the clearing edge
  task automatic clear_pulse();
    @(negedge clk_i); cnt_rst_i = 1'b1;
    @(negedge clk_i); cnt_rst_i = 1'b0;
    @(negedge clk_i);
  endtask

  // compares every cycle against the model; k-th negedge shows position k-1
  task automatic sweep(input string rq_h, input string rq_v, input int n, input int drop_at);
    int bad_h = 0, bad_v = 0;
    logic fh_a = 1'b0, fh_e = 1'b0, fv_a = 1'b0, fv_e = 1'b0;
    for (int k = 1; k <= n; k++) begin
      int p, h, v;
      @(negedge clk_i);
      p = (k - 1) % FRAME;
      h = p % CPL;
      v = p / CPL;
      if (hsync_no !== exp_hs(h)) begin
        if (bad_h == 0) begin fh_a = hsync_no; fh_e = exp_hs(h); end
        bad_h++;
      end
      if (vsync_no !== exp_vs(h, v)) begin
        if (bad_v == 0) begin fv_a = vsync_no; fv_e = exp_vs(h, v); end
        bad_v++;
      end
      if (k == drop_at) cnt_rst_i = 1'b0;
    end
    check({rq_h, " hsync_no first mismatch"}, (bad_h == 0) ? fh_e : fh_a, fh_e);
    check({rq_v, " vsync_no first mismatch"}, (bad_v == 0) ? fv_e : fv_a, fv_e);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #20;
    check("R1 hsync_no in reset", hsync_no, 1'b1);
    check("R1 vsync_no in reset", vsync_no, 1'b1);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_vpulse(input logic [1:0] w, input logic [1:0] o,
                          input logic [1:0] sh, input logic [1:0] sk);
    cfg(1'b1, 2'd2, w, o, sh, sk);
    clear_pulse();
    sweep("R2 R3 R9", "R4 R5 R3", FRAME + 50, -1);
  endtask

  task automatic t_field(input logic [1:0] o, input logic [1:0] sh, input logic [1:0] sk);
    cfg(1'b1, 2'd1, 2'd1, o, sh, sk);
    clear_pulse();
    sweep("R2 R3", "R6 R5", FRAME + 50, -1);
  endtask

  task automatic t_line0(input logic [1:0] md);
    cfg(1'b1, md, 2'd2, 2'd3, 2'd3, 2'd1);
    clear_pulse();
    sweep("R2", "R7", FRAME + 50, -1);
  endtask

  task automatic t_slave();
    cfg(1'b0, 2'd2, 2'd3, 2'd1, 2'd3, 2'd0);
    clear_pulse();
    sweep("R8", "R8", FRAME, -1);
  endtask

  // reset released with the bit high; the later fall must not restart the frame
  task automatic t_orphan_fall();
    @(negedge clk_i);
    rst_ni = 1'b0;
    master_i = 1'b1; mode_i = 2'd2; hs_width_i = 2'd1; hs_vs_off_i = 2'd0;
    shared_i = 2'd2; skew_i = 2'd0; cnt_rst_i = 1'b1;
    @(negedge clk_i); rst_ni = 1'b1;
    sweep("R9 orphan", "R9 orphan", FRAME + 100, 300);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_vpulse(2'd0, 2'd0, 2'd0, 2'd0);
    t_vpulse(2'd1, 2'd1, 2'd1, 2'd1);
    t_vpulse(2'd2, 2'd2, 2'd2, 2'd2);
    t_vpulse(2'd3, 2'd3, 2'd3, 2'd3);
    t_field(2'd2, 2'b00, 2'd0);
    t_field(2'd1, 2'b01, 2'd1);
    t_field(2'd3, 2'b10, 2'd3);
    t_field(2'd0, 2'b11, 2'd2);
    t_line0(2'd0);
    t_line0(2'd3);
    t_slave();
    t_orphan_fall();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule